// File: doc/BRIEF.md
# Segment Address Translator with Access Protection

This block turns a two-part logical address (a segment number plus an offset within that segment) into a physical address. It keeps a small descriptor table in on-chip registers. Each descriptor holds the segment's starting physical address, its length, a present flag and three permission flags. A separate count register states how many segments the current context may use.

Every lookup also carries an access kind: read, write or execute. The unit checks the segment number against the count and the present flag. It then checks the offset against the segment length and the access kind against the permission flags. The registered result is either a physical address or a numbered fault.

Descriptors are loaded through a single write port, one entry per cycle. The count register has its own load strobe. Lookups may be issued every cycle and are fully pipelined, with one register stage.

Top module: `seg_xlate_unit`

## Requirements
- R1: After reset every descriptor reads as not present with zero base, zero length and no permissions, the segment count is 0 and `rsp_valid` is 0, so the first lookup after reset reports fault code 1.
- R2: `rsp_valid` is high in exactly the cycle after a cycle with `req_valid` high, and low otherwise.
- R3: A lookup whose segment number is greater than or equal to the segment count reports fault code 1.
- R4: A lookup to a descriptor whose present flag is 0 reports fault code 2.
- R5: A lookup whose offset is greater than or equal to the descriptor length reports fault code 3; a length of 0 makes every offset fault.
- R6: Access kind encoding is 0 read, 1 write, 2 execute and 3 reserved. Permission bit 0 grants read, bit 1 grants write and bit 2 grants execute. A kind whose bit is clear, or kind 3, reports fault code 4.
- R7: When several fault conditions hold at once, the lowest nonzero code (1 < 2 < 3 < 4) is reported.
- R8: With no fault the result is code 0 and `rsp_paddr` = base + offset modulo 2^24. On any fault `rsp_paddr` is 0.
- R9: A descriptor write or count write in the same cycle as a lookup does not affect that lookup, which sees the previous contents.
- R10: In a cycle with no request, `rsp_paddr` and `rsp_fault` keep the values of the last response.
- R11: A descriptor written in one cycle is used by every lookup from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tbl_we | input | 1 | Descriptor write strobe |
| tbl_idx | input | 4 | Descriptor index to write |
| tbl_base | input | 24 | Segment start physical address |
| tbl_limit | input | 16 | Segment length |
| tbl_present | input | 1 | Present flag for the written descriptor |
| tbl_perm | input | 3 | Permission flags: bit 0 read, bit 1 write, bit 2 execute |
| cnt_we | input | 1 | Segment count write strobe |
| cnt_val | input | 5 | New segment count (0 to 16) |
| req_valid | input | 1 | Lookup request |
| req_seg | input | 4 | Segment number |
| req_off | input | 16 | Offset within the segment |
| req_kind | input | 2 | Access kind |
| rsp_valid | output | 1 | Result valid, one cycle after the request |
| rsp_paddr | output | 24 | Physical address, 0 on fault |
| rsp_fault | output | 3 | Fault code: 0 none, 1 segment out of range, 2 not present, 3 offset past length, 4 permission |

## Verification
Directed lookups each isolate one check. There is a segment number just at and just below the count, and an offset equal to the length and one below it. There is a zero-length segment, each access kind against each single permission flag, and a base near the top of the address space to expose wraparound. Each of these separates one fault code from its neighbours. Combined faults set two conditions at once, so a wrong priority shows up as the higher code. Writes issued alongside a lookup to the same entry show whether old or new contents are used. A long run of random writes and lookups over a small index range then mixes all conditions against the bench model.

// File: rtl/segxlat_pkg.sv
package segxlat_pkg;

    localparam int SEG_COUNT = 16;
    localparam int IDX_W     = $clog2(SEG_COUNT);
    localparam int CNT_W     = $clog2(SEG_COUNT + 1);
    localparam int BASE_W    = 24;
    localparam int LIMIT_W   = 16;
    localparam int PA_W      = BASE_W;
    localparam int PERM_W    = 3;

    typedef enum logic [2:0] {
        FLT_NONE      = 3'd0,
        FLT_SEG_RANGE = 3'd1,
        FLT_ABSENT    = 3'd2,
        FLT_OFFSET    = 3'd3,
        FLT_PERM      = 3'd4
    } fault_e;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    typedef struct packed {
        logic                present;
        logic [PERM_W-1:0]   perm;
        logic [LIMIT_W-1:0]  limit;
        logic [BASE_W-1:0]   base;
    } seg_desc_t;

endpackage

// File: rtl/seg_desc_table.sv
module seg_desc_table
    import segxlat_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  seg_desc_t        wr_desc,
    input  logic [IDX_W-1:0] rd_idx,
    output seg_desc_t        rd_desc
);

    seg_desc_t desc_d [SEG_COUNT];
    seg_desc_t desc_q [SEG_COUNT];

    for (genvar g = 0; g < SEG_COUNT; g++) begin : g_entry
        always_comb begin
            desc_d[g] = desc_q[g];
            if (wr_en && (wr_idx == IDX_W'(g))) begin
                desc_d[g] = wr_desc;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                desc_q[g] <= '0;
            end else begin
                desc_q[g] <= desc_d[g];
            end
        end
    end

    // read side sees registered contents only: same-cycle writes are not visible
    assign rd_desc = desc_q[rd_idx];

    // R11: a write lands in the addressed entry by the next cycle
    a_r11_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (desc_q[$past(wr_idx)] == $past(wr_desc)));

    // R1: reset clears every entry to not present
    a_r1_entry0_cleared: assert property (@(posedge clk)
        !rst_n |=> (!desc_q[0].present || $past(wr_en)));

endmodule

// File: rtl/seg_access_check.sv
module seg_access_check
    import segxlat_pkg::*;
(
    input  seg_desc_t           desc,
    input  logic [CNT_W-1:0]    seg_cnt,
    input  logic [IDX_W-1:0]    seg_num,
    input  logic [LIMIT_W-1:0]  offset,
    input  acc_e                kind,
    output fault_e              fault,
    output logic [PA_W-1:0]     paddr
);

    logic seg_out;
    logic off_out;
    logic perm_ok;

    always_comb begin
        seg_out = ({1'b0, seg_num} >= seg_cnt);
        off_out = (offset >= desc.limit);
        unique case (kind)
            ACC_READ:  perm_ok = desc.perm[0];
            ACC_WRITE: perm_ok = desc.perm[1];
            ACC_EXEC:  perm_ok = desc.perm[2];
            default:   perm_ok = 1'b0;
        endcase
    end

    // lowest code wins
    always_comb begin
        if (seg_out) begin
            fault = FLT_SEG_RANGE;
        end else if (!desc.present) begin
            fault = FLT_ABSENT;
        end else if (off_out) begin
            fault = FLT_OFFSET;
        end else if (!perm_ok) begin
            fault = FLT_PERM;
        end else begin
            fault = FLT_NONE;
        end
    end

    always_comb begin
        if (fault == FLT_NONE) begin
            paddr = desc.base + PA_W'(offset);
        end else begin
            paddr = '0;
        end
    end

endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit
    import segxlat_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tbl_we,
    input  logic [IDX_W-1:0]   tbl_idx,
    input  logic [BASE_W-1:0]  tbl_base,
    input  logic [LIMIT_W-1:0] tbl_limit,
    input  logic               tbl_present,
    input  logic [PERM_W-1:0]  tbl_perm,
    input  logic               cnt_we,
    input  logic [CNT_W-1:0]   cnt_val,
    input  logic               req_valid,
    input  logic [IDX_W-1:0]   req_seg,
    input  logic [LIMIT_W-1:0] req_off,
    input  logic [1:0]         req_kind,
    output logic               rsp_valid,
    output logic [PA_W-1:0]    rsp_paddr,
    output logic [2:0]         rsp_fault
);

    typedef struct packed {
        logic             vld;
        logic [PA_W-1:0]  pa;
        fault_e           flt;
        logic [CNT_W-1:0] cnt;
    } xl_state_t;

    xl_state_t st_d;
    xl_state_t st_q;

    seg_desc_t wr_desc;
    seg_desc_t rd_desc;
    fault_e    chk_fault;
    logic [PA_W-1:0] chk_paddr;

    always_comb begin
        wr_desc.present = tbl_present;
        wr_desc.perm    = tbl_perm;
        wr_desc.limit   = tbl_limit;
        wr_desc.base    = tbl_base;
    end

    seg_desc_table i_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (tbl_we),
        .wr_idx  (tbl_idx),
        .wr_desc (wr_desc),
        .rd_idx  (req_seg),
        .rd_desc (rd_desc)
    );

    seg_access_check i_check (
        .desc    (rd_desc),
        .seg_cnt (st_q.cnt),
        .seg_num (req_seg),
        .offset  (req_off),
        .kind    (acc_e'(req_kind)),
        .fault   (chk_fault),
        .paddr   (chk_paddr)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = req_valid;
        if (req_valid) begin
            st_d.pa  = chk_paddr;
            st_d.flt = chk_fault;
        end
        if (cnt_we) begin
            st_d.cnt = cnt_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{vld: 1'b0, pa: '0, flt: FLT_NONE, cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid = st_q.vld;
    assign rsp_paddr = st_q.pa;
    assign rsp_fault = st_q.flt;

    // R2: one response per request, one cycle later
    a_r2_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    a_r2_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R3: segment beyond the count faults with code 1
    a_r3_seg_range: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && ({1'b0, req_seg} >= st_q.cnt)) |=> (rsp_fault == 3'd1));

    // R4: absent descriptor faults with code 2 when in range
    a_r4_absent: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && ({1'b0, req_seg} < st_q.cnt) && !rd_desc.present)
        |=> (rsp_fault == 3'd2));

    // R8: a faulting response never carries an address
    a_r8_fault_zero_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && (rsp_fault != 3'd0)) |-> (rsp_paddr == '0));

    // R7: only defined codes appear
    a_r7_code_range: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_fault <= 3'd4));

    // R10: idle cycles leave the result untouched
    a_r10_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> ($stable(rsp_paddr) && $stable(rsp_fault)));

endmodule

// File: tb/test_seg_xlate_unit.sv
`timescale 1ns/1ps
module test_seg_xlate_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tbl_we = 1'b0;
    logic [3:0]  tbl_idx = '0;
    logic [23:0] tbl_base = '0;
    logic [15:0] tbl_limit = '0;
    logic        tbl_present = 1'b0;
    logic [2:0]  tbl_perm = '0;
    logic        cnt_we = 1'b0;
    logic [4:0]  cnt_val = '0;
    logic        req_valid = 1'b0;
    logic [3:0]  req_seg = '0;
    logic [15:0] req_off = '0;
    logic [1:0]  req_kind = '0;
    logic        rsp_valid;
    logic [23:0] rsp_paddr;
    logic [2:0]  rsp_fault;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [23:0] m_base  [16];
    logic [15:0] m_limit [16];
    logic        m_pres  [16];
    logic [2:0]  m_perm  [16];
    logic [4:0]  m_cnt;

    always #10 clk = ~clk;

    seg_xlate_unit i_seg_xlate_unit (
        .clk(clk), .rst_n(rst_n),
        .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_base(tbl_base),
        .tbl_limit(tbl_limit), .tbl_present(tbl_present), .tbl_perm(tbl_perm),
        .cnt_we(cnt_we), .cnt_val(cnt_val),
        .req_valid(req_valid), .req_seg(req_seg), .req_off(req_off),
        .req_kind(req_kind),
        .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault)
    );

    function automatic logic [2:0] exp_fault(input logic [3:0] s,
                                             input logic [15:0] o,
                                             input logic [1:0] k);
        if ({1'b0, s} >= m_cnt)          return 3'd1;
        if (!m_pres[s])                  return 3'd2;
        if (o >= m_limit[s])             return 3'd3;
        if (k == 2'd3 || !m_perm[s][k])  return 3'd4;
        return 3'd0;
    endfunction

    function automatic logic [23:0] exp_paddr(input logic [3:0] s,
                                              input logic [15:0] o,
                                              input logic [1:0] k);
        if (exp_fault(s, o, k) != 3'd0) return 24'd0;
        return m_base[s] + {8'd0, o};
    endfunction

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic put_desc(input logic [3:0] i, input logic [23:0] b,
                            input logic [15:0] l, input logic p, input logic [2:0] pm);
        @(negedge clk);
        tbl_we = 1; tbl_idx = i; tbl_base = b; tbl_limit = l;
        tbl_present = p; tbl_perm = pm;
        @(negedge clk);
        tbl_we = 0;
        m_base[i] = b; m_limit[i] = l; m_pres[i] = p; m_perm[i] = pm;
    endtask

    task automatic put_cnt(input logic [4:0] c);
        @(negedge clk);
        cnt_we = 1; cnt_val = c;
        @(negedge clk);
        cnt_we = 0;
        m_cnt = c;
    endtask

    // issue one lookup, optionally with a same-cycle descriptor write
    task automatic lookup(input logic [3:0] s, input logic [15:0] o,
                          input logic [1:0] k, input string tag,
                          input bit with_wr = 0, input logic [3:0] wi = 0,
                          input logic [23:0] wb = 0, input logic [15:0] wl = 0,
                          input logic wp = 0, input logic [2:0] wpm = 0);
        logic [2:0]  ef;
        logic [23:0] ea;
        ef = exp_fault(s, o, k);
        ea = exp_paddr(s, o, k);
        @(negedge clk);
        req_valid = 1; req_seg = s; req_off = o; req_kind = k;
        if (with_wr) begin
            tbl_we = 1; tbl_idx = wi; tbl_base = wb; tbl_limit = wl;
            tbl_present = wp; tbl_perm = wpm;
        end
        @(negedge clk);
        req_valid = 0; tbl_we = 0;
        if (with_wr) begin
            m_base[wi] = wb; m_limit[wi] = wl; m_pres[wi] = wp; m_perm[wi] = wpm;
        end
        check(rsp_valid === 1'b1, {tag, " R2 valid"}, 32'(rsp_valid), 32'd1);
        check(rsp_fault === ef, {tag, " fault"}, 32'(rsp_fault), 32'(ef));
        check(rsp_paddr === ea, {tag, " paddr"}, 32'(rsp_paddr), 32'(ea));
    endtask

    initial begin
        #3_000_000;
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [23:0] held;
        void'($urandom(32'd4711));
        for (int i = 0; i < 16; i++) begin
            m_base[i] = '0; m_limit[i] = '0; m_pres[i] = 0; m_perm[i] = '0;
        end
        m_cnt = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check(rsp_valid === 1'b0, "R1 reset valid", 32'(rsp_valid), 0);
        check(rsp_fault === 3'd0, "R1 reset fault", 32'(rsp_fault), 0);
        lookup(4'd0, 16'd0, 2'd0, "R1 count zero");

        put_desc(4'd0, 24'h001000, 16'h0100, 1, 3'b001);
        put_desc(4'd1, 24'h020000, 16'h0010, 1, 3'b010);
        put_desc(4'd2, 24'h300000, 16'h0040, 1, 3'b100);
        put_desc(4'd3, 24'hFFFFF0, 16'h0040, 1, 3'b111);
        put_desc(4'd4, 24'h000500, 16'h0000, 1, 3'b111);
        put_desc(4'd5, 24'h000700, 16'h0020, 0, 3'b111);
        put_cnt(5'd6);

        lookup(4'd5, 16'd0, 2'd0, "R3 R4 seg below count, absent");
        lookup(4'd6, 16'd0, 2'd0, "R3 seg equals count");
        lookup(4'd15, 16'd0, 2'd0, "R3 top seg");
        lookup(4'd0, 16'h00FF, 2'd0, "R5 R8 last offset");
        lookup(4'd0, 16'h0100, 2'd0, "R5 offset equals limit");
        lookup(4'd4, 16'd0, 2'd0, "R5 zero length");
        lookup(4'd0, 16'd4, 2'd1, "R6 write on read-only");
        lookup(4'd1, 16'd4, 2'd1, "R6 write allowed");
        lookup(4'd1, 16'd4, 2'd2, "R6 exec on write-only");
        lookup(4'd2, 16'd4, 2'd2, "R6 exec allowed");
        lookup(4'd3, 16'd4, 2'd3, "R6 reserved kind");
        lookup(4'd3, 16'h0020, 2'd0, "R8 wraparound");
        lookup(4'd5, 16'hFFFF, 2'd0, "R7 absent over offset");
        lookup(4'd0, 16'hFFFF, 2'd2, "R7 offset over perm");
        lookup(4'd7, 16'hFFFF, 2'd3, "R7 range over all");

        // R10: idle cycle keeps last result
        lookup(4'd2, 16'd8, 2'd2, "R10 prime");
        held = rsp_paddr;
        @(negedge clk);
        check(rsp_valid === 1'b0, "R2 idle valid", 32'(rsp_valid), 0);
        check(rsp_paddr === held, "R10 hold paddr", 32'(rsp_paddr), 32'(held));

        // R9: same-cycle write is not seen by the lookup; R11: seen afterwards
        lookup(4'd5, 16'd1, 2'd0, "R9 write same cycle",
               1, 4'd5, 24'h000900, 16'h0020, 1, 3'b001);
        lookup(4'd5, 16'd1, 2'd0, "R11 write visible next");
        @(negedge clk);
        req_valid = 1; req_seg = 4'd6; req_off = 0; req_kind = 0;
        cnt_we = 1; cnt_val = 5'd16;
        @(negedge clk);
        req_valid = 0; cnt_we = 0; m_cnt = 5'd16;
        check(rsp_fault === 3'd1, "R9 count write same cycle", 32'(rsp_fault), 1);

        for (int n = 0; n < 400; n++) begin
            if ($urandom_range(3) == 0) begin
                put_desc(4'($urandom_range(15)), 24'($urandom),
                         16'($urandom_range(64)), 1'($urandom_range(4) != 0),
                         3'($urandom));
            end else if ($urandom_range(15) == 0) begin
                put_cnt(5'($urandom_range(16)));
            end else begin
                lookup(4'($urandom_range(15)), 16'($urandom_range(80)),
                       2'($urandom), "R8 random");
            end
        end

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule